// File: doc/BRIEF.md
# Debug Access Security Filter

This block guards the register space of an on-chip debug support unit against an external debugger whenever the device is locked. It has an AHB slave port that faces the debug access port's bus master, and a simple single-cycle request port for the CPU. Each side drives its own target port toward a dual-ported register bank. A lock status derived from a code-protect bit and a multi-bit debug-lock field decides whether external transfers are screened.

When the device is locked, an external transfer is forwarded only if its byte offset lies in the open window [0x0100, 0x2000). A transfer anywhere else never reaches the bank and ends with the two-cycle AHB ERROR response. The first 0x100 bytes of the map hold the operating registers. A second copy of them at 0x0100 to 0x01FF lets debugger traffic be recognised by address alone: both copies are folded onto the same bank offset. Forwarded external transfers also carry a restricted flag while the device is locked, so the bank can refuse debugger commands that are forbidden. CPU requests are folded the same way and are never filtered.

Top module: `dbg_sec_filter`

## Requirements
- R1: The device counts as locked when `code_prot_i` is 1 or any bit of `dbg_lock_i` is 1. Every other input combination counts as unlocked.
- R2: While locked, an external NONSEQ or SEQ transfer (`htrans` 2 or 3) whose offset is below 0x0100 or at or above 0x2000 is not forwarded: `xt_req_o` stays 0 for that transfer. The response is two cycles: `hreadyout` 0 with `hresp` 1 (ERROR), then `hreadyout` 1 with `hresp` 1.
- R3: While locked, an external transfer whose offset lies in [0x0100, 0x2000) is forwarded in its data phase with zero wait states and an OKAY response (`hresp` 0).
- R4: While unlocked, every external transfer is forwarded with an OKAY response and zero wait states, whatever its offset.
- R5: A forwarded offset in [0x0100, 0x0200) reaches the target as offset minus 0x0100. Any other offset reaches the target unchanged. Write data and the write flag pass through in the data phase, and read data returns from the target in the same cycle.
- R6: `xt_restricted_o` is 1 during the data phase of a forwarded external transfer exactly when the device was locked at that transfer's address phase. It is 0 at all other times.
- R7: The CPU path is combinational and is never filtered. `ct_req_o`, `ct_we_o`, the folded `ct_addr_o` (folded as in R5) and `ct_wdata_o` follow the CPU inputs in the same cycle. `cpu_rdata_o` equals `ct_rdata_i`.
- R8: An IDLE or BUSY transfer (`htrans` 0 or 1) gets an OKAY response with `hreadyout` 1 and is never forwarded, even while locked and outside the open window.
- R9: No address phase is taken in the first error cycle. A transfer presented during the second error cycle is accepted and gets its data phase in the next cycle.
- R10: After reset, `ext_hreadyout_o` is 1, `ext_hresp_o` is 0, `xt_req_o` is 0 and `ext_hrdata_o` is 0. The read data bus returns 0 whenever no external read is being forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| code_prot_i | input | 1 | Code-protect status bit |
| dbg_lock_i | input | LOCK_W | Debug-lock fuse field; any non-zero value locks |
| ext_hsel_i | input | 1 | AHB slave select from the debug master |
| ext_haddr_i | input | ADDR_W | AHB byte offset |
| ext_htrans_i | input | 2 | AHB transfer type |
| ext_hwrite_i | input | 1 | AHB write flag |
| ext_hwdata_i | input | DATA_W | AHB write data (data phase) |
| ext_hready_i | input | 1 | AHB bus ready |
| ext_hrdata_o | output | DATA_W | AHB read data |
| ext_hreadyout_o | output | 1 | AHB slave ready |
| ext_hresp_o | output | 1 | AHB response, 1 = ERROR |
| cpu_req_i | input | 1 | CPU access request |
| cpu_we_i | input | 1 | CPU write flag |
| cpu_addr_i | input | ADDR_W | CPU byte offset |
| cpu_wdata_i | input | DATA_W | CPU write data |
| cpu_rdata_o | output | DATA_W | CPU read data |
| xt_req_o | output | 1 | Bank request, external side |
| xt_we_o | output | 1 | Bank write enable, external side |
| xt_addr_o | output | ADDR_W | Folded bank offset, external side |
| xt_wdata_o | output | DATA_W | Bank write data, external side |
| xt_restricted_o | output | 1 | Forwarded debugger access made while locked |
| xt_rdata_i | input | DATA_W | Bank read data, external side |
| ct_req_o | output | 1 | Bank request, CPU side |
| ct_we_o | output | 1 | Bank write enable, CPU side |
| ct_addr_o | output | ADDR_W | Folded bank offset, CPU side |
| ct_wdata_o | output | DATA_W | Bank write data, CPU side |
| ct_rdata_i | input | DATA_W | Bank read data, CPU side |

## Verification
The bench sweeps the whole offset space against every lock combination. This includes lock values that set only the upper bit, which a filter testing only bit 0 would treat as unlocked. It probes the edges of the window at 0x00FC/0x0100, 0x01FC/0x0200 and 0x1FFC/0x2000. A closed or open off-by-one bound would forward a blocked word or reject a legal one, and a bad fold would send alias traffic to the wrong register. The bench also checks that a blocked write never raises the bank request and that the ERROR response lasts exactly two cycles. Finally, it presents a new transfer across both error cycles: a port that accepted it in the first cycle, or dropped it in the second, would show the wrong data phase.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FWD  = 2'd1,
        PH_ERR1 = 2'd2,
        PH_ERR2 = 2'd3
    } phase_e;

    localparam logic [1:0] TRANS_IDLE   = 2'b00;
    localparam logic [1:0] TRANS_BUSY   = 2'b01;
    localparam logic [1:0] TRANS_NONSEQ = 2'b10;
    localparam logic [1:0] TRANS_SEQ    = 2'b11;

    localparam logic RESP_OKAY  = 1'b0;
    localparam logic RESP_ERROR = 1'b1;

endpackage

// File: rtl/dsf_addr_map.sv
module dsf_addr_map #(
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned WIN_BYTES = 256,
    parameter int unsigned OPEN_LO   = 256,
    parameter int unsigned OPEN_HI   = 8192
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] folded_o,
    output logic              in_open_o,
    output logic              via_alias_o
);
    localparam int unsigned AW1 = ADDR_W + 1;
    localparam logic [ADDR_W:0] ALIAS_LO = AW1'(WIN_BYTES);
    localparam logic [ADDR_W:0] ALIAS_HI = AW1'(2 * WIN_BYTES);
    localparam logic [ADDR_W:0] LO_X     = AW1'(OPEN_LO);
    localparam logic [ADDR_W:0] HI_X     = AW1'(OPEN_HI);
    localparam logic [ADDR_W-1:0] SHIFT  = ADDR_W'(WIN_BYTES);

    logic [ADDR_W:0] addr_x;

    always_comb begin
        addr_x      = {1'b0, addr_i};
        via_alias_o = (addr_x >= ALIAS_LO) && (addr_x < ALIAS_HI);
        in_open_o   = (addr_x >= LO_X) && (addr_x < HI_X);
        folded_o    = via_alias_o ? (addr_i - SHIFT) : addr_i;
    end

endmodule

// File: rtl/dsf_ahb_port.sv
module dsf_ahb_port
    import dsf_pkg::*;
#(
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned WIN_BYTES = 256,
    parameter int unsigned OPEN_LO   = 256,
    parameter int unsigned OPEN_HI   = 8192
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              locked_i,
    input  logic              hsel_i,
    input  logic [ADDR_W-1:0] haddr_i,
    input  logic [1:0]        htrans_i,
    input  logic              hwrite_i,
    input  logic [DATA_W-1:0] hwdata_i,
    input  logic              hready_i,
    output logic [DATA_W-1:0] hrdata_o,
    output logic              hreadyout_o,
    output logic              hresp_o,
    output logic              tgt_req_o,
    output logic              tgt_we_o,
    output logic [ADDR_W-1:0] tgt_addr_o,
    output logic [DATA_W-1:0] tgt_wdata_o,
    output logic              tgt_restricted_o,
    input  logic [DATA_W-1:0] tgt_rdata_i
);
    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              restricted;
    } port_st_t;

    localparam port_st_t ST_RESET = '{ph: PH_IDLE, addr: '0, write: 1'b0, restricted: 1'b0};

    port_st_t          st_d, st_q;
    logic [ADDR_W-1:0] folded;
    logic              in_open;
    logic              via_alias;
    logic              take;
    logic              blocked;

    dsf_addr_map #(
        .ADDR_W   (ADDR_W),
        .WIN_BYTES(WIN_BYTES),
        .OPEN_LO  (OPEN_LO),
        .OPEN_HI  (OPEN_HI)
    ) i_map (
        .addr_i     (haddr_i),
        .folded_o   (folded),
        .in_open_o  (in_open),
        .via_alias_o(via_alias)
    );

    always_comb begin
        st_d    = st_q;
        take    = hsel_i && hready_i && htrans_i[1];
        blocked = locked_i && !in_open;
        if (st_q.ph == PH_ERR1) begin
            st_d.ph = PH_ERR2;
        end else if (take) begin
            if (blocked) begin
                st_d.ph         = PH_ERR1;
                st_d.write      = 1'b0;
                st_d.restricted = 1'b0;
            end else begin
                st_d.ph         = PH_FWD;
                st_d.addr       = folded;
                st_d.write      = hwrite_i;
                st_d.restricted = locked_i;
            end
        end else begin
            st_d.ph = PH_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_RESET;
        else         st_q <= st_d;
    end

    always_comb begin
        hreadyout_o      = (st_q.ph != PH_ERR1);
        hresp_o          = (st_q.ph == PH_ERR1 || st_q.ph == PH_ERR2) ? RESP_ERROR : RESP_OKAY;
        tgt_req_o        = (st_q.ph == PH_FWD);
        tgt_we_o         = (st_q.ph == PH_FWD) && st_q.write;
        tgt_addr_o       = st_q.addr;
        tgt_wdata_o      = hwdata_i;
        tgt_restricted_o = (st_q.ph == PH_FWD) && st_q.restricted;
        hrdata_o         = ((st_q.ph == PH_FWD) && !st_q.write) ? tgt_rdata_i : '0;
    end

    localparam int unsigned AW1 = ADDR_W + 1;
    logic chk_outside;
    assign chk_outside = ({1'b0, haddr_i} < AW1'(OPEN_LO)) || ({1'b0, haddr_i} >= AW1'(OPEN_HI));

    // R2
    blocked_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hsel_i && hready_i && htrans_i[1] && locked_i && chk_outside)
        |=> (!hreadyout_o && hresp_o && !tgt_req_o));

    // R9
    err_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hreadyout_o) |=> (hreadyout_o && hresp_o && !tgt_req_o));

    // R8
    idle_okay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hsel_i && hready_i && !htrans_i[1] && hreadyout_o)
        |=> (hreadyout_o && !hresp_o && !tgt_req_o));

    // R4
    open_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hsel_i && hready_i && htrans_i[1] && !locked_i && hreadyout_o)
        |=> (tgt_req_o && hreadyout_o && !hresp_o));

    // R6
    restricted_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tgt_restricted_o |-> (tgt_req_o && $past(locked_i)));

endmodule

// File: rtl/dbg_sec_filter.sv
module dbg_sec_filter
    import dsf_pkg::*;
#(
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned LOCK_W    = 2,
    parameter int unsigned WIN_BYTES = 256,
    parameter int unsigned OPEN_LO   = 256,
    parameter int unsigned OPEN_HI   = 8192
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              code_prot_i,
    input  logic [LOCK_W-1:0] dbg_lock_i,
    input  logic              ext_hsel_i,
    input  logic [ADDR_W-1:0] ext_haddr_i,
    input  logic [1:0]        ext_htrans_i,
    input  logic              ext_hwrite_i,
    input  logic [DATA_W-1:0] ext_hwdata_i,
    input  logic              ext_hready_i,
    output logic [DATA_W-1:0] ext_hrdata_o,
    output logic              ext_hreadyout_o,
    output logic              ext_hresp_o,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              xt_req_o,
    output logic              xt_we_o,
    output logic [ADDR_W-1:0] xt_addr_o,
    output logic [DATA_W-1:0] xt_wdata_o,
    output logic              xt_restricted_o,
    input  logic [DATA_W-1:0] xt_rdata_i,
    output logic              ct_req_o,
    output logic              ct_we_o,
    output logic [ADDR_W-1:0] ct_addr_o,
    output logic [DATA_W-1:0] ct_wdata_o,
    input  logic [DATA_W-1:0] ct_rdata_i
);
    logic              locked;
    logic [ADDR_W-1:0] cpu_folded;
    logic              cpu_in_open;
    logic              cpu_via_alias;

    assign locked = code_prot_i || (|dbg_lock_i);

    dsf_ahb_port #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .WIN_BYTES(WIN_BYTES),
        .OPEN_LO  (OPEN_LO),
        .OPEN_HI  (OPEN_HI)
    ) i_ext_port (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .locked_i        (locked),
        .hsel_i          (ext_hsel_i),
        .haddr_i         (ext_haddr_i),
        .htrans_i        (ext_htrans_i),
        .hwrite_i        (ext_hwrite_i),
        .hwdata_i        (ext_hwdata_i),
        .hready_i        (ext_hready_i),
        .hrdata_o        (ext_hrdata_o),
        .hreadyout_o     (ext_hreadyout_o),
        .hresp_o         (ext_hresp_o),
        .tgt_req_o       (xt_req_o),
        .tgt_we_o        (xt_we_o),
        .tgt_addr_o      (xt_addr_o),
        .tgt_wdata_o     (xt_wdata_o),
        .tgt_restricted_o(xt_restricted_o),
        .tgt_rdata_i     (xt_rdata_i)
    );

    dsf_addr_map #(
        .ADDR_W   (ADDR_W),
        .WIN_BYTES(WIN_BYTES),
        .OPEN_LO  (OPEN_LO),
        .OPEN_HI  (OPEN_HI)
    ) i_cpu_map (
        .addr_i     (cpu_addr_i),
        .folded_o   (cpu_folded),
        .in_open_o  (cpu_in_open),
        .via_alias_o(cpu_via_alias)
    );

    always_comb begin
        ct_req_o    = cpu_req_i;
        ct_we_o     = cpu_req_i && cpu_we_i;
        ct_addr_o   = cpu_folded;
        ct_wdata_o  = cpu_wdata_i;
        cpu_rdata_o = ct_rdata_i;
    end

    // R7
    cpu_unfiltered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_req_i && locked && !cpu_in_open) |-> ct_req_o);

    // R5
    cpu_fold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_req_i && cpu_via_alias) |-> (ct_addr_o < ADDR_W'(WIN_BYTES)));

endmodule

// File: tb/test_dbg_sec_filter.sv
module test_dbg_sec_filter;
    localparam int AW = 14;
    localparam int DW = 32;
    localparam int LW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cp = 1'b0;
    logic [LW-1:0] lock = '0;
    logic          hsel = 1'b0;
    logic [AW-1:0] haddr = '0;
    logic [1:0]    htrans = 2'b00;
    logic          hwrite = 1'b0;
    logic [DW-1:0] hwdata = '0;
    logic          hready;
    logic [DW-1:0] hrdata;
    logic          hreadyout, hresp;
    logic          creq = 1'b0, cwe = 1'b0;
    logic [AW-1:0] caddr = '0;
    logic [DW-1:0] cwdata = '0;
    logic [DW-1:0] crdata;
    logic          xreq, xwe, xrestr;
    logic [AW-1:0] xaddr;
    logic [DW-1:0] xwdata, xrdata;
    logic          treq, twe;
    logic [AW-1:0] taddr;
    logic [DW-1:0] twdata, trdata;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign hready = hreadyout;
    assign xrdata = 32'hC0DE_0000 | 32'(xaddr);
    assign trdata = 32'h5EED_0000 | 32'(taddr);

    dbg_sec_filter i_dbg_sec_filter (
        .clk_i(clk), .rst_ni(rst_n), .code_prot_i(cp), .dbg_lock_i(lock),
        .ext_hsel_i(hsel), .ext_haddr_i(haddr), .ext_htrans_i(htrans),
        .ext_hwrite_i(hwrite), .ext_hwdata_i(hwdata), .ext_hready_i(hready),
        .ext_hrdata_o(hrdata), .ext_hreadyout_o(hreadyout), .ext_hresp_o(hresp),
        .cpu_req_i(creq), .cpu_we_i(cwe), .cpu_addr_i(caddr), .cpu_wdata_i(cwdata),
        .cpu_rdata_o(crdata),
        .xt_req_o(xreq), .xt_we_o(xwe), .xt_addr_o(xaddr), .xt_wdata_o(xwdata),
        .xt_restricted_o(xrestr), .xt_rdata_i(xrdata),
        .ct_req_o(treq), .ct_we_o(twe), .ct_addr_o(taddr), .ct_wdata_o(twdata),
        .ct_rdata_i(trdata)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int fold(input int a);
        return (a >= 'h100 && a < 'h200) ? a - 'h100 : a;
    endfunction

    // one external transfer, non-pipelined
    task automatic ext_xfer(input int a, input bit we);
        bit lk, blk;
        logic [DW-1:0] wd;
        lk  = cp || (lock != 0);                 // R1
        blk = lk && !(a >= 'h100 && a < 'h2000);
        wd  = 32'hA500_0000 ^ 32'(a);
        @(negedge clk);
        hsel = 1'b1; htrans = (a[6]) ? 2'b11 : 2'b10; haddr = AW'(a); hwrite = we;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwdata = wd;
        #1;
        if (blk) begin
            // R2 first error cycle, no forward
            chk(!xreq, "R2", xreq, 0);
            chk(!hreadyout && hresp, "R2", {hreadyout, hresp}, 2'b01);
            @(negedge clk);
            chk(hreadyout && hresp && !xreq, "R2", {hreadyout, hresp, xreq}, 3'b110);
        end else begin
            // R3 / R4 forwarded, zero wait, OKAY
            chk(xreq && hreadyout && !hresp, lk ? "R3" : "R4", {xreq, hreadyout, hresp}, 3'b110);
            chk(xaddr == AW'(fold(a)), "R5", xaddr, fold(a));
            chk(xwe == we, "R5", xwe, we);
            if (we) chk(xwdata == wd, "R5", xwdata, wd);
            else    chk(hrdata == (32'hC0DE_0000 | 32'(fold(a))), "R5", hrdata,
                        32'hC0DE_0000 | 32'(fold(a)));
            chk(xrestr == lk, "R6", xrestr, lk);
        end
    endtask

    task automatic cpu_probe(input int a, input bit we);
        logic [DW-1:0] wd;
        wd = 32'h0BAD_0000 ^ 32'(a);
        creq = 1'b1; cwe = we; caddr = AW'(a); cwdata = wd;
        #1;
        // R7 unfiltered, folded, same cycle
        chk(treq && (twe == we) && (taddr == AW'(fold(a))) && (twdata == wd),
            "R7", {treq, twe, taddr}, {1'b1, we, AW'(fold(a))});
        chk(crdata == (32'h5EED_0000 | 32'(fold(a))), "R7", crdata, 32'h5EED_0000 | 32'(fold(a)));
        creq = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int edges[12] = '{'h0, 'hFC, 'h100, 'h104, 'h1FC, 'h200, 'h204,
                          'h1FFC, 'h2000, 'h2004, 'h3FFC, 'h80};
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(hreadyout && !hresp && !xreq && hrdata == 0, "R10",
            {hreadyout, hresp, xreq}, 3'b100);
        rst_n = 1'b1;

        for (int c = 0; c < 8; c++) begin
            cp = c[2]; lock = LW'(c[1:0]);
            for (int a = 0; a < (1 << AW); a += 'h40) begin
                ext_xfer(a, 1'b0);
                ext_xfer(a, 1'b1);
                cpu_probe(a, a[6]);
            end
            foreach (edges[k]) begin
                ext_xfer(edges[k], 1'b0);
                ext_xfer(edges[k], 1'b1);
                cpu_probe(edges[k], 1'b1);
            end
        end

        // R8 IDLE and BUSY while locked, outside the window
        cp = 1'b1; lock = '0;
        for (int t = 0; t < 2; t++) begin
            @(negedge clk);
            hsel = 1'b1; htrans = 2'(t); haddr = AW'('h3000); hwrite = 1'b1;
            @(negedge clk);
            #1;
            chk(hreadyout && !hresp && !xreq, "R8", {hreadyout, hresp, xreq}, 3'b100);
            chk(hrdata == 0, "R10", hrdata, 0);
            hsel = 1'b0; htrans = 2'b00;
        end

        // R9 transfer held across both error cycles
        cp = 1'b0; lock = 2'b10;
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; haddr = AW'('h0040); hwrite = 1'b0;
        @(negedge clk);
        haddr = AW'('h0120);
        #1;
        chk(!hreadyout && hresp, "R9", {hreadyout, hresp}, 2'b01);
        @(negedge clk);
        #1;
        chk(hreadyout && hresp && !xreq, "R9", {hreadyout, hresp, xreq}, 3'b110);
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00;
        #1;
        chk(xreq && !hresp && xaddr == AW'('h20), "R9", {xreq, hresp, xaddr}, {2'b10, AW'('h20)});
        chk(hrdata == 32'hC0DE_0020 && xrestr, "R9", hrdata, 32'hC0DE_0020);
        @(negedge clk);
        #1;
        chk(!xreq && hreadyout && !hresp, "R9", {xreq, hreadyout, hresp}, 3'b010);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule